// File: doc/BRIEF.md
# Frame-aligned TDM serial transmitter

This block turns a stream of 16-bit channel words into a time-division multiplexed serial stream for a downstream receiver. Words arrive on a valid/ready input and are stored in a small FIFO. Four words make one frame. The block drives three outputs: a bit clock at half the system clock rate, an active-low frame marker and serial data sent most-significant bit first.

A frame begins only when all four of its words are already buffered. Once a frame has started, it therefore always runs to completion. While no frame is ready, the bit clock stays low, the frame marker stays high and the data line stays low. Every frame, including the first one after a pause of any length, starts with the marker, and the marker is followed directly by channel 0. The receiver can therefore never see its channels rotated.

When the next frame is already buffered as the last bit of the current frame finishes, the next frame marker starts on the very next bit-clock rising edge. The bit clock then keeps running without a gap.

Top module: `tdm_frame_tx`

## Requirements
- R1: While no frame is in progress, `ser_clk` is held low, `ser_fs_n` is held high and `ser_data` is held low. The bit clock produces no rising edge outside a frame.
- R2: A frame starts only when the FIFO holds at least 4 words. If fewer than 4 words are waiting, no frame marker and no bit clock appear, however long the wait.
- R3: During a frame, `ser_clk` toggles on every system clock cycle, which is half the system rate. A bit period therefore lasts 2 system cycles, and it starts with a rising edge.
- R4: Each frame opens with `ser_fs_n` low for exactly 2 bit periods. `ser_fs_n` changes only at bit-clock rising edges, and it never goes low while the data slots of a frame are being sent.
- R5: Data changes at bit-clock rising edges, and each word is sent MSB first. The MSB of channel 0 is sent in the bit period that immediately follows the two marker periods, which is the first rising edge with `ser_fs_n` high.
- R6: Each frame carries 64 data bits in slots 0 to 3, and slot k holds the (k+1)-th word of that frame in order of acceptance. No accepted word is lost or sent twice.
- R7: After a pause of any length, the first word sent is in the channel 0 slot, right after the frame marker.
- R8: If the next 4 words are buffered when the last bit of a frame ends, the next frame marker starts on the next bit-clock rising edge. Frame starts are then 132 system cycles apart.
- R9: `in_ready` is low exactly while the FIFO holds 8 words. A word is accepted on a rising clock edge with `in_valid` and `in_ready` both high.
- R10: After synchronous reset, `in_ready` is high and the serial outputs are in the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Channel word to enqueue |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | FIFO can accept a word |
| ser_clk | output | 1 | Bit clock, half the system rate, running only during frames |
| ser_fs_n | output | 1 | Active-low frame marker, lasting two bit periods |
| ser_data | output | 1 | Serial data, MSB first |

## Verification
A slot or bit counter that slips shows up on the first following frame. The word in channel 0 would then not match the oldest accepted word, and the decoded stream would be rotated. A bad marker counter shows up as a marker that is not exactly two bit periods wide. A bit period that is not exactly two cycles shows up at the first rising edge after the fault. A frame gate that opens early shows up as bit-clock edges while fewer than four words are buffered, within one system cycle of the fault.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  // Returns a counter width of at least 1 bit for values 0..n-1.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tdm_tx_fifo.sv
module tdm_tx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PTR_W = tdm_tx_pkg::idx_w(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  // The storage has no reset, so it can map onto RAM primitives.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
  assign full    = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_nxt;
      if (rd_en) rd_ptr <= rd_nxt;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing #(
  parameter int CH_NUM     = 4,
  parameter int WORD_W     = 16,
  parameter int FS_PERIODS = 2,
  localparam int SYNC_W = tdm_tx_pkg::idx_w(FS_PERIODS),
  localparam int BIT_W  = tdm_tx_pkg::idx_w(WORD_W),
  localparam int CH_W   = tdm_tx_pkg::idx_w(CH_NUM)
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_ready,
  output logic new_per,
  output logic stop,
  output logic nxt_sync,
  output logic nxt_ld
);
  logic              run_q, half_q, sync_q;
  logic [SYNC_W-1:0] sidx_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CH_W-1:0]   ch_q;
  logic sync_last, bit_last, ch_last, frame_end, boundary, start;

  assign sync_last = (sidx_q == SYNC_W'(FS_PERIODS - 1));
  assign bit_last  = (bit_q == BIT_W'(WORD_W - 1));
  assign ch_last   = (ch_q == CH_W'(CH_NUM - 1));
  assign frame_end = run_q && half_q && !sync_q && bit_last && ch_last;
  // When idle, every edge may start a frame. When running, only the edge
  // that closes a bit period (the end of its low half) can.
  assign boundary  = run_q ? half_q : 1'b1;
  assign start     = boundary && frame_ready && (!run_q || frame_end);
  assign stop      = frame_end && !frame_ready;
  assign new_per   = start || (run_q && half_q && !frame_end);
  assign nxt_sync  = start || (sync_q && !sync_last);
  assign nxt_ld    = !start && ((sync_q && sync_last) || (!sync_q && bit_last));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      half_q <= 1'b0;
      sync_q <= 1'b0;
      sidx_q <= '0;
      bit_q  <= '0;
      ch_q   <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      half_q <= 1'b0;
      sync_q <= 1'b1;
      sidx_q <= '0;
      bit_q  <= '0;
      ch_q   <= '0;
    end else if (stop) begin
      run_q  <= 1'b0;
      half_q <= 1'b0;
      sync_q <= 1'b0;
    end else if (run_q && !half_q) begin
      half_q <= 1'b1;
    end else if (new_per) begin
      half_q <= 1'b0;
      if (sync_q) begin
        if (sync_last) begin
          sync_q <= 1'b0;
          bit_q  <= '0;
          ch_q   <= '0;
        end else begin
          sidx_q <= sidx_q + 1'b1;
        end
      end else if (bit_last) begin
        bit_q <= '0;
        ch_q  <= ch_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              new_per,
  input  logic              stop,
  input  logic              nxt_sync,
  input  logic              nxt_ld,
  input  logic [WORD_W-1:0] word,
  output logic              ser_clk,
  output logic              ser_fs_n,
  output logic              ser_data
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_clk  <= 1'b0;
      ser_fs_n <= 1'b1;
      ser_data <= 1'b0;
      sh_q     <= '0;
    end else if (new_per) begin
      ser_clk  <= 1'b1;
      ser_fs_n <= !nxt_sync;
      if (nxt_sync) begin
        ser_data <= 1'b0;
      end else if (nxt_ld) begin
        ser_data <= word[WORD_W-1];
        sh_q     <= {word[WORD_W-2:0], 1'b0};
      end else begin
        ser_data <= sh_q[WORD_W-1];
        sh_q     <= {sh_q[WORD_W-2:0], 1'b0};
      end
    end else if (stop) begin
      ser_clk  <= 1'b0;
      ser_fs_n <= 1'b1;
      ser_data <= 1'b0;
    end else begin
      ser_clk  <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx #(
  parameter int CH_NUM     = 4,
  parameter int WORD_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int FS_PERIODS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              ser_clk,
  output logic              ser_fs_n,
  output logic              ser_data
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [CNT_W-1:0]  fifo_cnt;
  logic [WORD_W-1:0] head_word;
  logic fifo_full, push, pop, frame_ready;
  logic new_per, stop, nxt_sync, nxt_ld;

  assign in_ready    = !fifo_full;
  assign push        = in_valid && in_ready;
  assign frame_ready = (fifo_cnt >= CNT_W'(CH_NUM));
  assign pop         = new_per && nxt_ld;

  tdm_tx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data(in_data),
    .rd_en(pop), .rd_data(head_word), .count(fifo_cnt), .full(fifo_full)
  );

  tdm_tx_timing #(.CH_NUM(CH_NUM), .WORD_W(WORD_W), .FS_PERIODS(FS_PERIODS)) tim_i (
    .clk(clk), .rst(rst), .frame_ready(frame_ready), .new_per(new_per),
    .stop(stop), .nxt_sync(nxt_sync), .nxt_ld(nxt_ld)
  );

  tdm_tx_shifter #(.WORD_W(WORD_W)) shf_i (
    .clk(clk), .rst(rst), .new_per(new_per), .stop(stop), .nxt_sync(nxt_sync),
    .nxt_ld(nxt_ld), .word(head_word), .ser_clk(ser_clk), .ser_fs_n(ser_fs_n),
    .ser_data(ser_data)
  );
endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk #(
  parameter int CH_NUM     = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ser_clk,
  input logic             ser_fs_n,
  input logic             ser_data,
  input logic [CNT_W-1:0] fifo_cnt
);
  // R3
  clk_alt_chk: assert property (@(posedge clk) disable iff (rst)
    ser_clk |=> !ser_clk);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ser_clk && !$past(ser_clk)) |-> (ser_fs_n && !ser_data));

  // R4
  fs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_fs_n) |-> ser_clk);

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && !$past(ser_clk) && !$past(ser_clk, 2))
      |-> ($past(fifo_cnt) >= CNT_W'(CH_NUM) && !ser_fs_n));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));
endmodule

bind tdm_frame_tx tdm_tx_chk #(
  .CH_NUM(CH_NUM), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_fs_n(ser_fs_n),
  .ser_data(ser_data), .fifo_cnt(fifo_cnt)
);

// File: tb/tdm_frame_tx_tb_top.sv
module tdm_frame_tx_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready, ser_clk, ser_fs_n, ser_data;

  always #5 clk = ~clk;

  tdm_frame_tx dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .ser_clk(ser_clk), .ser_fs_n(ser_fs_n), .ser_data(ser_data)
  );

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  bit   finished = 0;

  // Decoder state
  bit prev_clk = 0, collecting = 0;
  int cyc = 0, last_rise = 0, last_start = -1, sync_cnt = 0, nbits = 0;
  int rise_cnt = 0, frames = 0, b2b = 0, stalls = 0;
  logic [15:0] word = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern_word(input int idx);
    case (idx % 4)
      0: return 16'hFFFF;
      1: return 16'h0000;
      2: return 16'hAAAA;
      default: return 16'h0505;
    endcase
  endfunction

  task automatic push_word(input logic [15:0] w);
    in_data  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp_q.push_back(w);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (in_valid && !in_ready) stalls++;
      if (ser_clk && !prev_clk) begin
        rise_cnt++;
        if (sync_cnt > 0 || collecting)
          check(cyc - last_rise == 2, "R3", "cycles per bit period", cyc - last_rise, 2);
        last_rise = cyc;
        if (!ser_fs_n) begin
          if (collecting) check(0, "R4", "marker inside data slots", nbits, 64);
          collecting = 0;
          if (sync_cnt == 0) begin
            if (last_start >= 0 && cyc - last_start == 132) b2b++;
            last_start = cyc;
          end
          sync_cnt++;
        end else begin
          if (sync_cnt > 0) begin
            check(sync_cnt == 2, "R4", "marker width in bit periods", sync_cnt, 2);
            sync_cnt   = 0;
            collecting = 1;
            nbits      = 0;
          end else if (!collecting) begin
            check(0, "R1", "bit clock edge outside a frame", rise_cnt, 0);
          end
          if (collecting) begin
            if (nbits % 16 == 0) begin
              if (exp_q.size() == 0)
                check(0, "R2", "word sent with none accepted", nbits, 0);
              else
                check(ser_data == exp_q[0][15], "R5", "first bit is MSB after marker",
                      ser_data, exp_q[0][15]);
            end
            word = {word[14:0], ser_data};
            nbits++;
            if (nbits % 16 == 0 && exp_q.size() > 0) begin
              if (nbits == 16)
                check(word == exp_q[0], "R7", "channel 0 word", word, exp_q[0]);
              else
                check(word == exp_q[0], "R6", "channel word in order", word, exp_q[0]);
              void'(exp_q.pop_front());
            end
            if (nbits == 64) begin
              collecting = 0;
              frames++;
            end
          end
        end
      end
      prev_clk = ser_clk;
    end
  end

  initial begin
    int r0;
    void'($urandom(32'd20240611));
    wait_cycles(5);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(ser_clk == 0, "R10", "ser_clk after reset", ser_clk, 0);
    check(ser_fs_n == 1, "R10", "ser_fs_n after reset", ser_fs_n, 1);
    check(ser_data == 0, "R10", "ser_data after reset", ser_data, 0);
    check(in_ready == 1, "R10", "in_ready after reset", in_ready, 1);

    // R2: a partial frame must not start
    for (int i = 0; i < 3; i++) push_word(pattern_word(i));
    r0 = rise_cnt;
    wait_cycles(120);
    check(rise_cnt == r0, "R2", "bit clock edges with 3 words queued", rise_cnt - r0, 0);
    check(ser_fs_n == 1, "R2", "marker with 3 words queued", ser_fs_n, 1);
    push_word(pattern_word(3));
    wait_cycles(160);
    check(frames == 1, "R2", "frames after fourth word", frames, 1);

    // R7: pattern frames with pauses and irregular word gaps
    for (int f = 0; f < 5; f++) begin
      for (int i = 0; i < 4; i++) begin
        push_word(pattern_word(i));
        wait_cycles($urandom_range(0, 3) + f * 11);
      end
      wait_cycles(140 + $urandom_range(0, 150));
      r0 = rise_cnt;
      wait_cycles(30);
      // R1 idle during pause
      check(rise_cnt == r0 && ser_clk == 0 && ser_fs_n == 1 && ser_data == 0,
            "R1", "outputs quiet during pause", rise_cnt - r0, 0);
    end
    check(frames == 6, "R7", "frames after paused pattern", frames, 6);

    // R9 and R8: burst of three frames back to back
    r0 = b2b;
    for (int i = 0; i < 12; i++) push_word(pattern_word(i));
    check(stalls > 0, "R9", "in_ready dropped when FIFO filled", stalls, 1);
    wait_cycles(450);
    check(b2b - r0 >= 2, "R8", "frame starts 132 cycles apart", b2b - r0, 2);

    // Random frames mixed with pattern frames
    for (int f = 0; f < 6; f++) begin
      for (int i = 0; i < 4; i++) begin
        push_word((f % 2 == 0) ? pattern_word(i) : 16'($urandom()));
        wait_cycles($urandom_range(0, 40));
      end
      if ($urandom_range(0, 1) == 1) wait_cycles($urandom_range(50, 300));
    end
    wait_cycles(600);
    check(exp_q.size() == 0, "R6", "words left unsent", exp_q.size(), 0);
    check(frames == 15, "R6", "total frames", frames, 15);
    check(ser_clk == 0 && ser_fs_n == 1, "R1", "idle after drain", ser_fs_n, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule